// File: doc/BRIEF.md
# Output-Disable Request Detector

This block watches four active-low request inputs, which usually come from external fault or emergency-stop sources. When a request is detected on an input, the block latches a sticky flag for that input. The flags feed two outputs. The first is a combined high-impedance request that a power-stage controller can use to float its outputs. The second is an interrupt line, which is gated by an enable bit.

Each input has its own 2-bit detection mode. In edge mode, the input is checked for a falling edge. In the three level modes, the input is sampled at a divided clock rate and must stay low for 16 consecutive samples before a request is taken as valid. The mode fields can be loaded only once after reset.

Software reaches the block through a single 16-bit register with one access port. A flag is cleared by reading it as 1 and then writing 0 to it. In a level mode, the clear also needs the input to have been sampled high after that read.

Top module: `odreq_detect`

## Requirements
- R1: After reset, the register reads 0x0000 and both `irq` and `hiz_req` are low.
- R2: In mode 00 (falling edge), a high-to-low transition on input i sets flag i. Flag i is register bit 12+i, so input 3 maps to bit 15. The flag reads as set no later than the third clock edge after the input changes. A steady low input does not set the flag again.
- R3: In level modes, the mode field sets the sample rate: 01 samples at clk/8, 10 at clk/16, and 11 at clk/128. A flag is set only after 16 consecutive low samples. A shorter low pulse sets nothing. The mode field for input i is at bits 2i+1:2i.
- R4: A flag clears only when a write with that bit at 0 follows a read that returned the bit as 1. A write of 0 that was not preceded by such a read leaves the flag set.
- R5: Writing 1 to a flag bit never sets or changes that flag.
- R6: In a level mode, a write of 0 after a read of 1 clears the flag only if the input was sampled high between the read and the write. Otherwise the flag stays set.
- R7: The first register write after reset loads all four mode fields. Every later write leaves bits 7:0 unchanged.
- R8: Bit 8 is the interrupt enable and can be written at any time. `irq` equals the enable ANDed with the OR of the four flags.
- R9: `hiz_req` is high exactly when at least one flag is set.
- R10: Bits 11:9 always read as 0.
- R11: If a flag's set condition and a valid clear write occur in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| od_req_n | input | 4 | Active-low request inputs, asynchronous |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Register contents |
| irq | output | 1 | Interrupt request |
| hiz_req | output | 1 | Combined high-impedance request |

## Verification
A new detection on an input and a software clear of that same input's flag can land on the same clock edge. The bench first arms the clear by reading the flag as 1 and lets the input return high. It then drops the input and issues the write of 0 exactly two cycles later. This places the write on the same edge where the synchronized falling edge is seen. The flag must still read as 1 afterwards. A following read and write pair, with no new edge, must then clear it.

// File: rtl/odreq_pkg.sv
package odreq_pkg;

    localparam int NUM_PINS     = 4;
    localparam int REG_W        = 16;
    localparam int DIV8_LOG2    = 3;
    localparam int DIV16_LOG2   = 4;
    localparam int DIV128_LOG2  = 7;

    typedef enum logic [1:0] {
        DET_FALL     = 2'b00,
        DET_LOW_D8   = 2'b01,
        DET_LOW_D16  = 2'b10,
        DET_LOW_D128 = 2'b11
    } det_mode_e;

    typedef struct packed {
        logic [NUM_PINS-1:0]      flag;
        logic [2:0]               rsvd;
        logic                     irq_en;
        det_mode_e [NUM_PINS-1:0] mode;
    } ctrl_reg_t;

    typedef struct packed {
        logic d8;
        logic d16;
        logic d128;
    } tick_t;

    function automatic logic sample_tick(det_mode_e m, tick_t t);
        case (m)
            DET_LOW_D8:   return t.d8;
            DET_LOW_D16:  return t.d16;
            DET_LOW_D128: return t.d128;
            default:      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/odreq_sync.sv
module odreq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/odreq_prescaler.sv
module odreq_prescaler
    import odreq_pkg::*;
#(
    parameter int CNT_W = DIV128_LOG2
) (
    input  logic  clk,
    input  logic  rst,
    output tick_t tick
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign tick.d8   = &cnt[DIV8_LOG2-1:0];
    assign tick.d16  = &cnt[DIV16_LOG2-1:0];
    assign tick.d128 = &cnt[DIV128_LOG2-1:0];
endmodule

// File: rtl/odreq_channel.sv
module odreq_channel
    import odreq_pkg::*;
#(
    parameter int LOW_RUN = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_s,
    input  det_mode_e mode,
    input  tick_t     tick,
    input  logic      rd_stb,
    input  logic      wr_stb,
    input  logic      wr_bit,
    output logic      flag
);
    localparam int              CNT_W    = $clog2(LOW_RUN + 1);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(LOW_RUN - 1);

    logic             prev;
    logic             arm;
    logic             high_seen;
    logic [CNT_W-1:0] low_cnt;
    logic             edge_mode;
    logic             sample;
    logic             set_evt;
    logic             clr_ok;

    assign edge_mode = (mode == DET_FALL);
    assign sample    = sample_tick(mode, tick);
    assign set_evt   = edge_mode ? (prev & ~pin_s)
                                 : (sample & ~pin_s & (low_cnt >= RUN_LAST));
    assign clr_ok    = arm & wr_stb & ~wr_bit & (edge_mode | high_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev      <= 1'b1;
            arm       <= 1'b0;
            high_seen <= 1'b0;
            low_cnt   <= '0;
            flag      <= 1'b0;
        end else begin
            prev <= pin_s;

            if (sample) begin
                if (pin_s)                    low_cnt <= '0;
                else if (low_cnt != RUN_LAST) low_cnt <= low_cnt + 1'b1;
            end

            if (set_evt)     flag <= 1'b1;
            else if (clr_ok) flag <= 1'b0;

            if (wr_stb)      arm <= 1'b0;
            else if (rd_stb) arm <= flag;

            if (rd_stb)               high_seen <= 1'b0;
            else if (sample && pin_s) high_seen <= 1'b1;
        end
    end
endmodule

// File: rtl/odreq_detect.sv
module odreq_detect
    import odreq_pkg::*;
#(
    parameter int LOW_RUN     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] od_req_n,
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                irq,
    output logic                hiz_req
);
    ctrl_reg_t                wr_view;
    ctrl_reg_t                rd_view;
    det_mode_e [NUM_PINS-1:0] mode_q;
    logic                     mode_locked;
    logic                     irq_en_q;
    logic [NUM_PINS-1:0]      flags;
    logic                     rd_stb;
    logic                     wr_stb;
    tick_t                    tick;
    logic                     unused_rsvd;

    assign wr_view     = ctrl_reg_t'(reg_wdata);
    assign unused_rsvd = ^wr_view.rsvd;
    assign rd_stb      = reg_en & ~reg_we;
    assign wr_stb      = reg_en & reg_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= {NUM_PINS{DET_FALL}};
            mode_locked <= 1'b0;
            irq_en_q    <= 1'b0;
        end else if (wr_stb) begin
            irq_en_q <= wr_view.irq_en;
            if (!mode_locked) begin
                mode_q      <= wr_view.mode;
                mode_locked <= 1'b1;
            end
        end
    end

    odreq_prescaler #(.CNT_W(DIV128_LOG2)) i_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic pin_s;

        odreq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
            .clk (clk),
            .rst (rst),
            .d   (od_req_n[p]),
            .q   (pin_s)
        );

        odreq_channel #(.LOW_RUN(LOW_RUN)) i_chan (
            .clk    (clk),
            .rst    (rst),
            .pin_s  (pin_s),
            .mode   (mode_q[p]),
            .tick   (tick),
            .rd_stb (rd_stb),
            .wr_stb (wr_stb),
            .wr_bit (wr_view.flag[p]),
            .flag   (flags[p])
        );
    end

    always_comb begin
        rd_view        = '0;
        rd_view.flag   = flags;
        rd_view.irq_en = irq_en_q;
        rd_view.mode   = mode_q;
    end

    assign reg_rdata = rd_view;
    assign hiz_req   = |flags;
    assign irq       = irq_en_q & (|flags);
endmodule

// File: rtl/odreq_checker.sv
module odreq_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_en,
    input logic        reg_we,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        irq,
    input logic        hiz_req
);
    logic seen_wr;
    logic mode_frozen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_wr     <= 1'b0;
            mode_frozen <= 1'b0;
        end else begin
            if (reg_en && reg_we) seen_wr <= 1'b1;
            mode_frozen <= seen_wr;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (reg_rdata == 16'h0000 && !irq && !hiz_req));

    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[11:9] == 3'b000);

    assert_hiz_any_R9: assert property (@(posedge clk) disable iff (rst)
        hiz_req == (|reg_rdata[15:12]));

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (reg_rdata[8] && hiz_req));

    assert_mode_once_R7: assert property (@(posedge clk) disable iff (rst)
        mode_frozen |-> $stable(reg_rdata[7:0]));

    for (genvar b = 12; b < 16; b++) begin : g_clr
        assert_clear_by_write_R4: assert property (@(posedge clk) disable iff (rst)
            $fell(reg_rdata[b]) |-> ($past(rst) || $past(reg_en && reg_we && !reg_wdata[b])));
    end
endmodule

bind odreq_detect odreq_checker i_odreq_checker (
    .clk       (clk),
    .rst       (rst),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .hiz_req   (hiz_req)
);

// File: tb/test_odreq_detect.sv
module test_odreq_detect;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  od_req_n;
    logic        reg_en;
    logic        reg_we;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        irq;
    logic        hiz_req;

    int checks   = 0;
    int failures = 0;

    odreq_detect i_odreq_detect (
        .clk       (clk),
        .rst       (rst),
        .od_req_n  (od_req_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .hiz_req   (hiz_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst = 1'b1; od_req_n = 4'hF; reg_en = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(output logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        reset_dut();
        chk(reg_rdata == 16'h0 && !irq && !hiz_req, "R1 reset state", reg_rdata, 0);
    endtask

    task automatic t_edge();
        reset_dut();
        wr(16'h0000);
        @(negedge clk); od_req_n[3] = 1'b0;
        idle(3);
        chk(reg_rdata[15] == 1'b1, "R2 falling edge sets bit15", reg_rdata[15], 1);
        chk(reg_rdata[14:12] == 3'b000, "R2 other flags clear", reg_rdata[14:12], 0);
        chk(hiz_req == 1'b1, "R9 hiz on flag", hiz_req, 1);
    endtask

    task automatic t_no_read_clear();
        logic [15:0] v;
        wr(16'h0000);
        idle(2);
        chk(reg_rdata[15] == 1'b1, "R4 write0 without read ignored", reg_rdata[15], 1);
        rd(v);
        chk(v[15] == 1'b1, "R4 read returns 1", v[15], 1);
        wr(16'h7000);
        idle(5);
        chk(reg_rdata[15] == 1'b0, "R4 read1 then write0 clears", reg_rdata[15], 0);
        chk(hiz_req == 1'b0, "R9 hiz drops", hiz_req, 0);
        chk(reg_rdata[15] == 1'b0, "R2 steady low does not set again", reg_rdata[15], 0);
    endtask

    task automatic t_write_one();
        reset_dut();
        wr(16'hF000);
        idle(2);
        chk(reg_rdata[15:12] == 4'h0 && !hiz_req, "R5 write1 sets nothing", reg_rdata[15:12], 0);
    endtask

    task automatic t_irq();
        reset_dut();
        wr(16'h0100);
        @(negedge clk); od_req_n[2] = 1'b0;
        idle(4);
        chk(irq == 1'b1 && reg_rdata[14], "R8 irq with enable", irq, 1);
        wr(16'h0000);
        idle(1);
        chk(irq == 1'b0 && hiz_req, "R8 irq masked, hiz held", {irq, hiz_req}, 1);
        chk(reg_rdata[8] == 1'b0, "R8 enable rewritable", reg_rdata[8], 0);
    endtask

    task automatic t_mode_once();
        logic [15:0] v;
        reset_dut();
        wr(16'h0EE4);
        rd(v);
        chk(v[7:0] == 8'hE4, "R7 first write loads modes", v[7:0], 8'hE4);
        chk(v[11:9] == 3'b000, "R10 reserved bits zero", v[11:9], 0);
        wr(16'h001B);
        rd(v);
        chk(v[7:0] == 8'hE4, "R7 later write ignored", v[7:0], 8'hE4);
        @(negedge clk); od_req_n[0] = 1'b0;
        idle(4);
        chk(reg_rdata[12] == 1'b1, "R7 pin0 still edge mode", reg_rdata[12], 1);
    endtask

    task automatic t_level();
        reset_dut();
        wr(16'h0009);
        @(negedge clk); od_req_n[1:0] = 2'b00;
        idle(60);
        od_req_n[1:0] = 2'b11;
        idle(40);
        chk(reg_rdata[13:12] == 2'b00, "R3 short low ignored", reg_rdata[13:12], 0);
        od_req_n[1:0] = 2'b00;
        idle(200);
        chk(reg_rdata[13:12] == 2'b01, "R3 div8 set, div16 not yet", reg_rdata[13:12], 1);
        idle(120);
        chk(reg_rdata[13:12] == 2'b11, "R3 div16 set", reg_rdata[13:12], 3);
    endtask

    task automatic t_level_clear();
        logic [15:0] v;
        reset_dut();
        wr(16'h0030);
        @(negedge clk); od_req_n[2] = 1'b0;
        for (int i = 0; i < 3000 && !reg_rdata[14]; i++) @(negedge clk);
        chk(reg_rdata[14] == 1'b1, "R3 div128 set", reg_rdata[14], 1);
        rd(v);
        od_req_n[2] = 1'b1;
        wr(16'hB000);
        idle(1);
        chk(reg_rdata[14] == 1'b1, "R6 no high sample, clear ignored", reg_rdata[14], 1);
        rd(v);
        idle(300);
        wr(16'hB000);
        idle(1);
        chk(reg_rdata[14] == 1'b0, "R6 clear after high sample", reg_rdata[14], 0);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        reset_dut();
        wr(16'h0000);
        @(negedge clk); od_req_n[0] = 1'b0;
        idle(4);
        rd(v);
        od_req_n[0] = 1'b1;
        idle(4);
        @(negedge clk); od_req_n[0] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_wdata = 16'hE000;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        chk(reg_rdata[12] == 1'b1, "R11 set wins over clear", reg_rdata[12], 1);
        rd(v);
        wr(16'hE000);
        idle(1);
        chk(reg_rdata[12] == 1'b0, "R11 later clear works", reg_rdata[12], 0);
    endtask

    initial begin
        rst = 1'b1; od_req_n = 4'hF; reg_en = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        t_reset();
        t_edge();
        t_no_read_clear();
        t_write_one();
        t_irq();
        t_mode_once();
        t_level();
        t_level_clear();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0x%0h expected=0x%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule